// File: doc/BRIEF.md
# Solid Rectangle Fill Engine

This block paints an axis-aligned rectangle of a byte-addressed frame buffer with one color. A command carries the rectangle's x and y position, its width and height in pixels, the row pitch and base offset in bytes, a pixel-format code, a vertical direction flag, a raster-operation code, a 32-bit brush color and two 24-bit palette colors. After `start` is sampled while the engine is idle, the engine checks the geometry and the operation. It then streams the rectangle into memory one byte per clock through a simple write port.

The raster-operation code selects the fill color. It can be the brush color, or one of the two palette entries with an opaque alpha byte forced on top. When the fill ends, the engine presents the updated destination y for the caller's register. A command that fails the checks is dropped without any memory write, and a one-cycle reject pulse gives the reason.

Top module: `rect_fill_engine`

## Requirements
- R1: Raster-operation code 0xF0 fills with the 32-bit brush color unchanged.
- R2: Code 0x00 fills with 0xFF in bits 31:24 and palette entry 0 packed as red 23:16, green 15:8, blue 7:0.
- R3: Code 0xFF fills with 0xFF in bits 31:24 and palette entry 1 packed the same way as in R2.
- R4: The pixel-format code sets the bytes per pixel: 2 gives 1, 3 or 4 give 2, 5 gives 3, 6 gives 4. Each pixel is written as that many low bytes of the fill value, least significant byte at the lowest address.
- R5: The top row is written first and rows follow in increasing order. Row r starts at offset + (top + r) × pitch + x × bytes-per-pixel, and its bytes are written at consecutive ascending addresses. The engine writes one byte every clock with no gaps. If `start` is sampled at edge E, the cycle after E is a check cycle and the first write is presented in the cycle after that.
- R6: With the direction flag set, top = y. With the flag clear, top = y + 1 − height (16-bit wrap).
- R7: `busy` is high from the edge that accepts `start` until the cycle after `done`. `done` is a single-cycle pulse in the cycle after the last write. During `done`, `y_new` holds top + height when the flag is set, and top otherwise.
- R8: The geometry is rejected, with a `geom_bad` pulse in the check cycle and no write and no `done`, in any of these cases: the format code is not one of those in R4; the pitch is zero; x or top exceeds 0x3FFF; the offset is at or above MEM_BYTES; or offset + x + (top + height) × pitch is at or above MEM_BYTES.
- R9: Any other raster-operation code raises `op_bad` in the check cycle, with no write and no `done`. A geometry fault takes priority, so only `geom_bad` is raised when both apply.
- R10: A zero width or zero height produces no writes. `done` follows the check cycle, with `y_new` as in R7.
- R11: `start` is ignored while `busy` is high. The command inputs are captured only when `start` is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a command while idle |
| rop | input | 8 | Raster-operation code |
| brush_color | input | 32 | Brush foreground color |
| pal0_r | input | 8 | Palette entry 0 red |
| pal0_g | input | 8 | Palette entry 0 green |
| pal0_b | input | 8 | Palette entry 0 blue |
| pal1_r | input | 8 | Palette entry 1 red |
| pal1_g | input | 8 | Palette entry 1 green |
| pal1_b | input | 8 | Palette entry 1 blue |
| pix_fmt | input | 4 | Pixel-format code |
| dst_x | input | 16 | Destination x in pixels |
| dst_y | input | 16 | Destination y (top or bottom row, per direction) |
| rect_w | input | 16 | Width in pixels |
| rect_h | input | 16 | Height in rows |
| row_pitch | input | 16 | Bytes per frame-buffer row |
| base_off | input | 24 | Frame-buffer byte offset |
| top_down | input | 1 | Vertical direction flag |
| busy | output | 1 | Command in progress |
| done | output | 1 | Completion pulse |
| y_new | output | 16 | Updated destination y, valid with done |
| op_bad | output | 1 | Unsupported operation pulse |
| geom_bad | output | 1 | Geometry reject pulse |
| wr_en | output | 1 | Memory byte write strobe |
| wr_addr | output | 24 | Memory byte address |
| wr_data | output | 8 | Memory byte data |

## Verification
A wrong byte counter or row base in the walker shows at `wr_addr` on the first write after the faulty step, no later than the first byte of the next pixel or row. A wrong color selection or byte lane shows in `wr_data` on the first write of the run. A wrong direction decode shows in the first address and again in `y_new` at `done`. Because the bench predicts every cycle, a fault in the check-cycle decision is caught one cycle after the start edge, either as a missing reject pulse or as an unexpected write.

// File: rtl/rfill_pkg.sv
package rfill_pkg;
    localparam int COORD_W = 16;
    localparam int ADDR_W  = 24;
    localparam int PITCH_W = 16;
    localparam int WIDE_W  = 48;
    localparam logic [COORD_W-1:0] COORD_MAX = 16'h3FFF;

    localparam logic [7:0] OP_BRUSH = 8'hF0;
    localparam logic [7:0] OP_BLACK = 8'h00;
    localparam logic [7:0] OP_WHITE = 8'hFF;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WRITE,
        ST_FINISH
    } fill_state_e;

    typedef struct packed {
        logic [7:0]         rop;
        logic [31:0]        brush;
        logic [23:0]        pal0;
        logic [23:0]        pal1;
        logic [3:0]         fmt;
        logic [COORD_W-1:0] x;
        logic [COORD_W-1:0] y;
        logic [COORD_W-1:0] w;
        logic [COORD_W-1:0] h;
        logic [PITCH_W-1:0] pitch;
        logic [ADDR_W-1:0]  offset;
        logic               top_down;
    } fill_cmd_t;

    function automatic logic [2:0] fmt_bytes(input logic [3:0] fmt);
        case (fmt)
            4'd2:       return 3'd1;
            4'd3, 4'd4: return 3'd2;
            4'd5:       return 3'd3;
            4'd6:       return 3'd4;
            default:    return 3'd0;
        endcase
    endfunction

    function automatic logic [31:0] opaque_rgb(input logic [23:0] rgb);
        return {8'hFF, rgb};
    endfunction
endpackage

// File: rtl/rfill_color.sv
module rfill_color
    import rfill_pkg::*;
(
    input  logic [7:0]  rop,
    input  logic [31:0] brush,
    input  logic [23:0] pal0,
    input  logic [23:0] pal1,
    output logic        op_ok,
    output logic [31:0] fill
);
    always_comb begin
        op_ok = 1'b1;
        fill  = 32'h0;
        case (rop)
            OP_BRUSH: fill = brush;
            OP_BLACK: fill = opaque_rgb(pal0);
            OP_WHITE: fill = opaque_rgb(pal1);
            default:  op_ok = 1'b0;
        endcase
    end
endmodule

// File: rtl/rfill_bounds.sv
module rfill_bounds
    import rfill_pkg::*;
#(
    parameter int MEM_BYTES = 1 << 20
) (
    input  logic [3:0]         fmt,
    input  logic [COORD_W-1:0] x,
    input  logic [COORD_W-1:0] y,
    input  logic [COORD_W-1:0] h,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [ADDR_W-1:0]  offset,
    input  logic               top_down,
    output logic               geom_ok,
    output logic [2:0]         bpp,
    output logic [COORD_W-1:0] top_row,
    output logic [COORD_W-1:0] end_row,
    output logic [ADDR_W-1:0]  start_addr
);
    localparam logic [WIDE_W-1:0] MEM_LIM = WIDE_W'(MEM_BYTES);

    logic [COORD_W:0]  top_plus_h;
    logic [WIDE_W-1:0] span;
    logic [WIDE_W-1:0] first_byte;

    always_comb begin
        bpp        = fmt_bytes(fmt);
        top_row    = top_down ? y : (y + COORD_W'(1) - h);
        top_plus_h = {1'b0, top_row} + {1'b0, h};
        end_row    = top_plus_h[COORD_W-1:0];
        span       = WIDE_W'(offset) + WIDE_W'(x)
                   + WIDE_W'(top_plus_h) * WIDE_W'(pitch);
        first_byte = WIDE_W'(offset) + WIDE_W'(top_row) * WIDE_W'(pitch)
                   + WIDE_W'(x) * WIDE_W'(bpp);
        start_addr = first_byte[ADDR_W-1:0];
        geom_ok    = (bpp != 3'd0) && (pitch != '0)
                   && (x <= COORD_MAX) && (top_row <= COORD_MAX)
                   && (WIDE_W'(offset) < MEM_LIM) && (span < MEM_LIM);
    end
endmodule

// File: rtl/rfill_walker.sv
module rfill_walker
    import rfill_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               load,
    input  logic               step,
    input  logic [ADDR_W-1:0]  start_addr,
    input  logic [PITCH_W-1:0] pitch,
    input  logic [COORD_W-1:0] w,
    input  logic [COORD_W-1:0] h,
    input  logic [2:0]         bpp,
    output logic [ADDR_W-1:0]  addr,
    output logic [1:0]         byte_sel,
    output logic               last
);
    logic [ADDR_W-1:0]  row_base_q;
    logic [COORD_W-1:0] col_q;
    logic [COORD_W-1:0] row_q;
    logic [COORD_W-1:0] w_q;
    logic [COORD_W-1:0] h_q;
    logic [2:0]         bpp_q;
    logic [PITCH_W-1:0] pitch_q;
    logic               pix_end;
    logic               row_end;

    assign pix_end = ({1'b0, byte_sel} == bpp_q - 3'd1);
    assign row_end = pix_end && (col_q == w_q - COORD_W'(1));
    assign last    = row_end && (row_q == h_q - COORD_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            addr       <= '0;
            row_base_q <= '0;
            byte_sel   <= '0;
            col_q      <= '0;
            row_q      <= '0;
            w_q        <= '0;
            h_q        <= '0;
            bpp_q      <= 3'd1;
            pitch_q    <= '0;
        end else if (load) begin
            addr       <= start_addr;
            row_base_q <= start_addr;
            byte_sel   <= '0;
            col_q      <= '0;
            row_q      <= '0;
            w_q        <= w;
            h_q        <= h;
            bpp_q      <= bpp;
            pitch_q    <= pitch;
        end else if (step) begin
            if (!pix_end) begin
                byte_sel <= byte_sel + 2'd1;
                addr     <= addr + ADDR_W'(1);
            end else if (!row_end) begin
                byte_sel <= '0;
                col_q    <= col_q + COORD_W'(1);
                addr     <= addr + ADDR_W'(1);
            end else begin
                byte_sel   <= '0;
                col_q      <= '0;
                row_q      <= row_q + COORD_W'(1);
                row_base_q <= row_base_q + ADDR_W'(pitch_q);
                addr       <= row_base_q + ADDR_W'(pitch_q);
            end
        end
    end

    // R4: the byte lane never passes the pixel size
    p_lane_in_pixel_r4: assert property (@(posedge clk) disable iff (rst)
        step |-> ({1'b0, byte_sel} < bpp_q));

    // R5: inside a row the address advances by exactly one byte
    p_row_contiguous_r5: assert property (@(posedge clk) disable iff (rst)
        (step && !row_end) |=> (addr == $past(addr) + ADDR_W'(1)));
endmodule

// File: rtl/rect_fill_engine.sv
module rect_fill_engine
    import rfill_pkg::*;
#(
    parameter int MEM_BYTES = 1 << 20
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  logic [7:0]         rop,
    input  logic [31:0]        brush_color,
    input  logic [7:0]         pal0_r,
    input  logic [7:0]         pal0_g,
    input  logic [7:0]         pal0_b,
    input  logic [7:0]         pal1_r,
    input  logic [7:0]         pal1_g,
    input  logic [7:0]         pal1_b,
    input  logic [3:0]         pix_fmt,
    input  logic [15:0]        dst_x,
    input  logic [15:0]        dst_y,
    input  logic [15:0]        rect_w,
    input  logic [15:0]        rect_h,
    input  logic [15:0]        row_pitch,
    input  logic [23:0]        base_off,
    input  logic               top_down,
    output logic               busy,
    output logic               done,
    output logic [15:0]        y_new,
    output logic               op_bad,
    output logic               geom_bad,
    output logic               wr_en,
    output logic [23:0]        wr_addr,
    output logic [7:0]         wr_data
);
    fill_state_e st_q, st_d;
    fill_cmd_t   cmd_q;

    logic               op_ok;
    logic [31:0]        fill;
    logic               geom_ok;
    logic [2:0]         bpp;
    logic [COORD_W-1:0] top_row;
    logic [COORD_W-1:0] end_row;
    logic [ADDR_W-1:0]  start_addr;
    logic               empty_rect;
    logic               go;
    logic               wr_last;
    logic [1:0]         byte_sel;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= ST_IDLE;
            cmd_q <= '0;
        end else begin
            st_q <= st_d;
            if (st_q == ST_IDLE && start) begin
                cmd_q <= '{rop: rop, brush: brush_color,
                           pal0: {pal0_r, pal0_g, pal0_b},
                           pal1: {pal1_r, pal1_g, pal1_b},
                           fmt: pix_fmt, x: dst_x, y: dst_y,
                           w: rect_w, h: rect_h, pitch: row_pitch,
                           offset: base_off, top_down: top_down};
            end
        end
    end

    rfill_color u_color (
        .rop   (cmd_q.rop),
        .brush (cmd_q.brush),
        .pal0  (cmd_q.pal0),
        .pal1  (cmd_q.pal1),
        .op_ok (op_ok),
        .fill  (fill)
    );

    rfill_bounds #(.MEM_BYTES(MEM_BYTES)) u_bounds (
        .fmt        (cmd_q.fmt),
        .x          (cmd_q.x),
        .y          (cmd_q.y),
        .h          (cmd_q.h),
        .pitch      (cmd_q.pitch),
        .offset     (cmd_q.offset),
        .top_down   (cmd_q.top_down),
        .geom_ok    (geom_ok),
        .bpp        (bpp),
        .top_row    (top_row),
        .end_row    (end_row),
        .start_addr (start_addr)
    );

    assign empty_rect = (cmd_q.w == '0) || (cmd_q.h == '0);
    assign go = (st_q == ST_CHECK) && geom_ok && op_ok && !empty_rect;

    rfill_walker u_walker (
        .clk        (clk),
        .rst        (rst),
        .load       (go),
        .step       (wr_en),
        .start_addr (start_addr),
        .pitch      (cmd_q.pitch),
        .w          (cmd_q.w),
        .h          (cmd_q.h),
        .bpp        (bpp),
        .addr       (wr_addr),
        .byte_sel   (byte_sel),
        .last       (wr_last)
    );

    always_comb begin
        st_d = st_q;
        case (st_q)
            ST_IDLE:   if (start) st_d = ST_CHECK;
            ST_CHECK: begin
                if (!geom_ok || !op_ok) st_d = ST_IDLE;
                else if (empty_rect)    st_d = ST_FINISH;
                else                    st_d = ST_WRITE;
            end
            ST_WRITE:  if (wr_last) st_d = ST_FINISH;
            ST_FINISH: st_d = ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    assign busy     = (st_q != ST_IDLE);
    assign done     = (st_q == ST_FINISH);
    assign wr_en    = (st_q == ST_WRITE);
    assign geom_bad = (st_q == ST_CHECK) && !geom_ok;
    assign op_bad   = (st_q == ST_CHECK) && geom_ok && !op_ok;
    assign wr_data  = 8'(fill >> {byte_sel, 3'b000});
    assign y_new    = cmd_q.top_down ? end_row : top_row;

    // R11: accepted start always enters the check cycle
    p_start_accepted_r11: assert property (@(posedge clk) disable iff (rst)
        (!busy && start) |=> (busy && !wr_en && !done));

    // R11: command stays frozen while the engine runs
    p_cmd_frozen_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !done) |=> $stable(cmd_q));

    // R7: the last walker byte is followed by the done pulse
    p_last_then_done_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_last) |=> (done && !wr_en));

    // R7: done lasts one cycle and returns to idle
    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    // R5: writes form one unbroken burst
    p_burst_unbroken_r5: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !wr_last) |=> wr_en);

    // R8/R9: a rejected command leaves without any write
    p_reject_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        (op_bad || geom_bad) |=> (!busy && !wr_en && !done));

    // R9: at most one reject reason per command
    p_one_reason_r9: assert property (@(posedge clk) disable iff (rst)
        $onehot0({op_bad, geom_bad, wr_en, done}));
endmodule

// File: tb/test_rect_fill_engine.sv
module test_rect_fill_engine;
    localparam int CLK_PERIOD = 10;
    localparam longint MEMB = 64'd1 << 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  rop = 8'h0;
    logic [31:0] brush_color = 32'h0;
    logic [7:0]  pal0_r = 8'h0, pal0_g = 8'h0, pal0_b = 8'h0;
    logic [7:0]  pal1_r = 8'h0, pal1_g = 8'h0, pal1_b = 8'h0;
    logic [3:0]  pix_fmt = 4'h0;
    logic [15:0] dst_x = 16'h0, dst_y = 16'h0, rect_w = 16'h0, rect_h = 16'h0;
    logic [15:0] row_pitch = 16'h0;
    logic [23:0] base_off = 24'h0;
    logic        top_down = 1'b1;
    logic        busy, done, op_bad, geom_bad, wr_en;
    logic [15:0] y_new;
    logic [23:0] wr_addr;
    logic [7:0]  wr_data;

    int checks = 0;
    int errors = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rect_fill_engine #(.MEM_BYTES(int'(MEMB))) i_rect_fill_engine (
        .clk(clk), .rst(rst), .start(start), .rop(rop),
        .brush_color(brush_color),
        .pal0_r(pal0_r), .pal0_g(pal0_g), .pal0_b(pal0_b),
        .pal1_r(pal1_r), .pal1_g(pal1_g), .pal1_b(pal1_b),
        .pix_fmt(pix_fmt), .dst_x(dst_x), .dst_y(dst_y),
        .rect_w(rect_w), .rect_h(rect_h), .row_pitch(row_pitch),
        .base_off(base_off), .top_down(top_down),
        .busy(busy), .done(done), .y_new(y_new), .op_bad(op_bad),
        .geom_bad(geom_bad), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data)
    );

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic set_cmd(input logic [7:0] op, input logic [3:0] fmt,
                           input int x, input int y, input int w, input int h,
                           input int pitch, input longint off, input bit td);
        rop = op; pix_fmt = fmt;
        dst_x = 16'(x); dst_y = 16'(y); rect_w = 16'(w); rect_h = 16'(h);
        row_pitch = 16'(pitch); base_off = 24'(off); top_down = td;
    endtask

    // Behavioural model of one command, then cycle-by-cycle comparison.
    task automatic run_cmd(input string tag, input bit poke);
        longint bpp, top, fillv, ey, span;
        bit geom, opok;
        longint exp_addr[$];
        longint exp_data[$];
        case (pix_fmt)
            4'd2: bpp = 1;
            4'd3, 4'd4: bpp = 2;
            4'd5: bpp = 3;
            4'd6: bpp = 4;
            default: bpp = 0;
        endcase
        top = top_down ? longint'(dst_y) : ((longint'(dst_y) + 1 - longint'(rect_h)) & 64'hFFFF);
        span = longint'(base_off) + longint'(dst_x) + (top + longint'(rect_h)) * longint'(row_pitch);
        geom = (bpp != 0) && (row_pitch != 0) && (dst_x <= 16'h3FFF) && (top <= 64'h3FFF)
             && (longint'(base_off) < MEMB) && (span < MEMB);
        opok = 1'b1;
        fillv = 0;
        if (rop == 8'hF0) fillv = longint'(brush_color);
        else if (rop == 8'h00) fillv = 64'hFF000000 | (longint'(pal0_r) << 16) | (longint'(pal0_g) << 8) | longint'(pal0_b);
        else if (rop == 8'hFF) fillv = 64'hFF000000 | (longint'(pal1_r) << 16) | (longint'(pal1_g) << 8) | longint'(pal1_b);
        else opok = 1'b0;
        ey = top_down ? ((top + longint'(rect_h)) & 64'hFFFF) : top;
        if (geom && opok) begin
            for (longint r = 0; r < longint'(rect_h); r++)
                for (longint c = 0; c < longint'(rect_w); c++)
                    for (longint b = 0; b < bpp; b++) begin
                        exp_addr.push_back(longint'(base_off) + (top + r) * longint'(row_pitch)
                                           + (longint'(dst_x) + c) * bpp + b);
                        exp_data.push_back((fillv >> (8 * b)) & 64'hFF);
                    end
        end
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk({tag, " check cycle busy"}, longint'(busy), 1);
        chk({tag, " check cycle no write"}, longint'(wr_en), 0);
        chk({tag, " geom_bad (R8)"}, longint'(geom_bad), longint'(!geom));
        chk({tag, " op_bad (R9)"}, longint'(op_bad), longint'(geom && !opok));
        if (!(geom && opok)) begin
            @(negedge clk);
            chk({tag, " reject idle (R8/R9)"}, longint'({busy, done, wr_en}), 0);
            return;
        end
        for (int k = 0; exp_addr.size() > 0; k++) begin
            @(negedge clk);
            start = (poke && k == 0);
            chk({tag, " write strobe (R5)"}, longint'(wr_en), 1);
            chk({tag, " write addr (R5)"}, longint'(wr_addr), exp_addr.pop_front());
            chk({tag, " write data (R4)"}, longint'(wr_data), exp_data.pop_front());
        end
        @(negedge clk); start = 1'b0;
        chk({tag, " done pulse (R7)"}, longint'(done), 1);
        chk({tag, " no write at done (R7)"}, longint'(wr_en), 0);
        chk({tag, " y update (R7)"}, longint'(y_new), ey);
        @(negedge clk);
        chk({tag, " idle after done (R7/R11)"}, longint'({busy, done, wr_en}), 0);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        checks++; errors++;
        $display("FAIL watchdog: actual hung expected finished");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk("R7 reset busy", longint'(busy), 0);
        chk("R7 reset outputs", longint'({done, wr_en, op_bad, geom_bad}), 0);

        brush_color = 32'hA1B2C3D4;
        pal0_r = 8'h11; pal0_g = 8'h22; pal0_b = 8'h33;
        pal1_r = 8'hE1; pal1_g = 8'hE2; pal1_b = 8'hE3;

        set_cmd(8'hF0, 4'd6, 3, 2, 2, 2, 64, 'h100, 1'b1);
        run_cmd("R1 brush 32bpp", 1'b0);
        set_cmd(8'h00, 4'd2, 5, 7, 3, 2, 40, 'h2000, 1'b1);
        run_cmd("R2 black 8bpp", 1'b0);
        set_cmd(8'hFF, 4'd5, 1, 10, 2, 3, 30, 'h40, 1'b0);
        run_cmd("R3 R6 white 24bpp upward", 1'b0);
        set_cmd(8'hF0, 4'd3, 4, 0, 3, 1, 20, 'h0, 1'b1);
        run_cmd("R4 16bpp fmt3", 1'b0);
        set_cmd(8'h00, 4'd4, 0, 9, 1, 4, 16, 'h500, 1'b0);
        run_cmd("R4 R6 16bpp fmt4 upward", 1'b0);
        set_cmd(8'hF0, 4'd6, 2, 5, 4, 0, 32, 'h0, 1'b1);
        run_cmd("R10 zero height", 1'b0);
        set_cmd(8'hFF, 4'd2, 2, 5, 0, 3, 32, 'h0, 1'b0);
        run_cmd("R10 zero width upward", 1'b0);
        set_cmd(8'hF0, 4'd6, 0, 0, 2, 2, 0, 'h0, 1'b1);
        run_cmd("R8 zero pitch", 1'b0);
        set_cmd(8'hF0, 4'd2, 'h4000, 0, 1, 1, 16, 'h0, 1'b1);
        run_cmd("R8 x limit", 1'b0);
        set_cmd(8'hF0, 4'd2, 0, 0, 1, 1, 16, MEMB, 1'b1);
        run_cmd("R8 offset at end", 1'b0);
        set_cmd(8'hF0, 4'd2, 0, 100, 1, 1, 20000, 'h0, 1'b1);
        run_cmd("R8 span past end", 1'b0);
        set_cmd(8'hF0, 4'd7, 0, 0, 1, 1, 16, 'h0, 1'b1);
        run_cmd("R8 bad format", 1'b0);
        set_cmd(8'hF0, 4'd2, 0, 0, 1, 2, 16, 'h0, 1'b0);
        run_cmd("R6 R8 upward underflow", 1'b0);
        set_cmd(8'h5A, 4'd2, 0, 0, 1, 1, 16, 'h0, 1'b1);
        run_cmd("R9 bad op", 1'b0);
        set_cmd(8'h5A, 4'd2, 0, 0, 1, 1, 0, 'h0, 1'b1);
        run_cmd("R9 geometry first", 1'b0);
        set_cmd(8'hF0, 4'd6, 1, 1, 2, 1, 64, 'h80, 1'b1);
        run_cmd("R11 start while busy", 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule